// File: doc/BRIEF.md
# Largest-Occupancy Channel Read Scheduler

This block decides which logical channel an external-memory buffer should drain next. It keeps a packet count for every channel: a write-complete event tagged with a channel raises that channel's count, and a read-complete event lowers it. Upstream logic posts read requests ahead of time into a small pool inside the block. Each request names a destination channel. The two most significant bits of a channel number select the memory bank that holds it.

When a search is started for a given bank, the block walks the request pool one slot per cycle. It keeps the best candidate among requests whose channel lies in that bank and holds at least one packet. The best candidate is the one with the most buffered packets, and the lower channel number wins a tie. After the fixed-length walk it pulses a completion strobe. If a candidate was found, it presents the channel and its packet count with a valid flag until the consumer accepts it. Acceptance frees the request slot. Packet-count overflow and underflow are recorded in a sticky error flag.

Top module: `occ_sched_top`

## Requirements
- R1: After reset all packet counts are zero, the request pool is empty, `req_full_o` is 0, and `done_o`, `sel_valid_o` and `err_o` are 0.
- R2: A one-cycle `wr_done_i` adds one to the count of channel `wr_ch_i`, and a one-cycle `rd_done_i` subtracts one from the count of channel `rd_ch_i`. Events on different channels in the same cycle both take effect.
- R3: A write-complete and a read-complete for the same channel in the same cycle leave that count unchanged and raise no error.
- R4: A write-complete on a channel whose count is all ones leaves the count at all ones and sets `err_o`. Once set, `err_o` stays 1 until reset.
- R5: A read-complete on a channel whose count is zero leaves the count at zero and sets `err_o`.
- R6: A search accepted at a clock edge ends with `done_o` high for exactly one cycle, REQ_DEPTH clock edges later. `sel_valid_o` can only rise together with `done_o`.
- R7: The result is the pending request whose channel bank, taken from channel bits [CH_W-1:CH_W-2], equals the `bank_i` value sampled at search start, and which has the largest packet count. `sel_cnt_o` reports that count.
- R8: Among qualifying requests with equal counts, the lowest channel number is chosen.
- R9: A channel with a zero count, or in another bank, is never chosen. If no request qualifies, `done_o` pulses with `sel_valid_o` low.
- R10: While `sel_valid_o` is high and `sel_ready_i` is low, `sel_ch_o` and `sel_cnt_o` hold steady. On acceptance `sel_valid_o` drops and the chosen request leaves the pool.
- R11: The pool holds REQ_DEPTH requests. `req_full_o` is 1 when every slot is occupied, and a push while full is dropped.
- R12: `start_i` is ignored while a search is running or a result is waiting for acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_done_i | input | 1 | Write-complete event |
| wr_ch_i | input | CH_W | Channel of the write-complete event |
| rd_done_i | input | 1 | Read-complete event |
| rd_ch_i | input | CH_W | Channel of the read-complete event |
| req_push_i | input | 1 | Post a read request into the pool |
| req_ch_i | input | CH_W | Destination channel of the posted request |
| req_full_o | output | 1 | All request slots occupied |
| bank_i | input | BANK_W | Bank to search, sampled at search start |
| start_i | input | 1 | Begin a search |
| done_o | output | 1 | One-cycle search-complete strobe |
| sel_valid_o | output | 1 | A chosen channel is presented |
| sel_ch_o | output | CH_W | Chosen channel |
| sel_cnt_o | output | CNT_W | Packet count of the chosen channel at search time |
| sel_ready_i | input | 1 | Consumer accepts the presented channel |
| err_o | output | 1 | Sticky count overflow or underflow flag |

## Verification
The bench builds the block with 16 channels, a 3-bit count and a 4-slot request pool. With 16 channels, the bank field is bits [3:2], so all four banks are reached with a handful of channel numbers. The 3-bit count reaches saturation after seven write-completes. The 4-slot pool fills after four pushes, so the full-pool drop and the exact four-cycle search latency can both be observed directly. Ties, empty channels, foreign-bank requests, simultaneous events and ignored starts are each driven by a directed scenario against hand-computed counts.

// File: rtl/occ_sched_pkg.sv
`timescale 1ns/1ps
package occ_sched_pkg;
  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_SCAN = 2'd1,
    PK_HOLD = 2'd2
  } pick_state_e;
endpackage

// File: rtl/occ_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module occ_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/occ_count_bank.sv
`timescale 1ns/1ps
// Per-channel packet counters with saturation and underflow guarding.
module occ_count_bank #(
  parameter int NUM_CH = 512,
  parameter int CNT_W  = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [CH_W-1:0]  inc_ch,
  input  logic             dec_en,
  input  logic [CH_W-1:0]  dec_ch,
  input  logic [CH_W-1:0]  look_ch,
  output logic [CNT_W-1:0] look_cnt,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_all [NUM_CH];
  logic             same_ch;
  logic             do_inc;
  logic             do_dec;
  logic             sat_hit;
  logic             und_hit;
  logic             err_q;
  logic             err_d;
  logic             err_en;

  // Event qualification: a matched pair on one channel cancels.
  always_comb begin
    same_ch = inc_en && dec_en && (inc_ch == dec_ch);
    do_inc  = inc_en && !same_ch;
    do_dec  = dec_en && !same_ch;
    sat_hit = do_inc && (cnt_all[inc_ch] == CNT_MAX);
    und_hit = do_dec && (cnt_all[dec_ch] == '0);
    err_en  = sat_hit || und_hit;
    err_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [CNT_W-1:0] c_q;
      logic [CNT_W-1:0] c_d;
      logic             c_en;
      logic             hit_inc;
      logic             hit_dec;

      always_comb begin
        hit_inc = do_inc && (inc_ch == CH_W'(g)) && !sat_hit;
        hit_dec = do_dec && (dec_ch == CH_W'(g)) && !und_hit;
        c_en    = hit_inc || hit_dec;
        c_d     = hit_inc ? (c_q + CNT_W'(1)) : (c_q - CNT_W'(1));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    c_q <= '0;
        else if (c_en) c_q <= c_d;
      end

      assign cnt_all[g] = c_q;
    end
  endgenerate

  assign look_cnt = cnt_all[look_ch];
  assign err_o    = err_q;
endmodule

// File: rtl/occ_req_pool.sv
`timescale 1ns/1ps
// Slot pool of pending read requests; push fills the lowest free slot.
module occ_req_pool #(
  parameter int DEPTH = 16,
  parameter int CH_W  = 9,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [CH_W-1:0]  push_ch,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [CH_W-1:0]  rd_ch,
  output logic             full
);
  logic [DEPTH-1:0] vld_vec;
  logic [CH_W-1:0]  ch_arr [DEPTH];
  logic [IDX_W-1:0] free_idx;
  logic             push_ok;

  // Lowest free slot wins; the descending loop leaves the lowest index.
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign full    = &vld_vec;
  assign push_ok = push_en && !full;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic            v_q;
      logic            v_d;
      logic            v_en;
      logic [CH_W-1:0] ch_q;
      logic            set_hit;
      logic            clr_hit;

      always_comb begin
        set_hit = push_ok && (free_idx == IDX_W'(g));
        clr_hit = clr_en && (clr_idx == IDX_W'(g));
        v_en    = set_hit || clr_hit;
        v_d     = set_hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    v_q <= 1'b0;
        else if (v_en) v_q <= v_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ch_q <= '0;
        else if (set_hit) ch_q <= push_ch;
      end

      assign vld_vec[g] = v_q;
      assign ch_arr[g]  = ch_q;
    end
  endgenerate

  assign rd_vld = vld_vec[rd_idx];
  assign rd_ch  = ch_arr[rd_idx];
endmodule

// File: rtl/occ_best_pick.sv
`timescale 1ns/1ps
// Sequential search: one pool slot per cycle, keeps the fullest in-bank channel.
module occ_best_pick
  import occ_sched_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CH_W   = 9,
  parameter int CNT_W  = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  slot_idx,
  input  logic              slot_vld,
  input  logic [CH_W-1:0]   slot_ch,
  output logic [CH_W-1:0]   look_ch,
  input  logic [CNT_W-1:0]  look_cnt,
  input  logic              ready,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              done,
  output logic              sel_valid,
  output logic [CH_W-1:0]   sel_ch,
  output logic [CNT_W-1:0]  sel_cnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  pick_state_e       st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              found_q, found_d;
  logic [CH_W-1:0]   best_ch_q, best_ch_d;
  logic [CNT_W-1:0]  best_cnt_q, best_cnt_d;
  logic [IDX_W-1:0]  best_slot_q, best_slot_d;
  logic              done_q, done_d;
  logic              cand;
  logic              better;

  assign slot_idx = idx_q;
  assign look_ch  = slot_ch;

  always_comb begin
    cand   = (st_q == PK_SCAN) && slot_vld &&
             (slot_ch[CH_W-1 -: BANK_W] == bank_q) && (look_cnt != '0);
    better = cand && (!found_q || (look_cnt > best_cnt_q) ||
                      ((look_cnt == best_cnt_q) && (slot_ch < best_ch_q)));
  end

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    bank_d      = bank_q;
    found_d     = found_q;
    best_ch_d   = best_ch_q;
    best_cnt_d  = best_cnt_q;
    best_slot_d = best_slot_q;
    done_d      = 1'b0;
    unique case (st_q)
      PK_IDLE: begin
        if (start) begin
          st_d    = PK_SCAN;
          idx_d   = '0;
          bank_d  = bank;
          found_d = 1'b0;
        end
      end
      PK_SCAN: begin
        if (better) begin
          found_d     = 1'b1;
          best_ch_d   = slot_ch;
          best_cnt_d  = look_cnt;
          best_slot_d = idx_q;
        end
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == LAST_IDX) begin
          done_d = 1'b1;
          st_d   = (found_q || better) ? PK_HOLD : PK_IDLE;
        end
      end
      PK_HOLD: begin
        if (ready) st_d = PK_IDLE;
      end
      default: st_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PK_IDLE;
      idx_q       <= '0;
      bank_q      <= '0;
      found_q     <= 1'b0;
      best_ch_q   <= '0;
      best_cnt_q  <= '0;
      best_slot_q <= '0;
      done_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      bank_q      <= bank_d;
      found_q     <= found_d;
      best_ch_q   <= best_ch_d;
      best_cnt_q  <= best_cnt_d;
      best_slot_q <= best_slot_d;
      done_q      <= done_d;
    end
  end

  assign clr_en    = (st_q == PK_HOLD) && ready;
  assign clr_idx   = best_slot_q;
  assign done      = done_q;
  assign sel_valid = (st_q == PK_HOLD);
  assign sel_ch    = best_ch_q;
  assign sel_cnt   = best_cnt_q;
endmodule

// File: rtl/occ_sched_top.sv
`timescale 1ns/1ps
// Largest-occupancy read scheduler: counters, request pool, sequential picker.
module occ_sched_top #(
  parameter int NUM_CH    = 512,
  parameter int CNT_W     = 8,
  parameter int BANK_W    = 2,
  parameter int REQ_DEPTH = 16,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int IDX_W    = (REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic              rd_done_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  input  logic              req_push_i,
  input  logic [CH_W-1:0]   req_ch_i,
  output logic              req_full_o,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              start_i,
  output logic              done_o,
  output logic              sel_valid_o,
  output logic [CH_W-1:0]   sel_ch_o,
  output logic [CNT_W-1:0]  sel_cnt_o,
  input  logic              sel_ready_i,
  output logic              err_o
);
  logic             rst_n_int;
  logic [IDX_W-1:0] slot_idx;
  logic             slot_vld;
  logic [CH_W-1:0]  slot_ch;
  logic [CH_W-1:0]  look_ch;
  logic [CNT_W-1:0] look_cnt;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;

  occ_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  occ_count_bank #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .CH_W   (CH_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .inc_en   (wr_done_i),
    .inc_ch   (wr_ch_i),
    .dec_en   (rd_done_i),
    .dec_ch   (rd_ch_i),
    .look_ch  (look_ch),
    .look_cnt (look_cnt),
    .err_o    (err_o)
  );

  occ_req_pool #(
    .DEPTH (REQ_DEPTH),
    .CH_W  (CH_W),
    .IDX_W (IDX_W)
  ) u_pool (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .push_en (req_push_i),
    .push_ch (req_ch_i),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .rd_idx  (slot_idx),
    .rd_vld  (slot_vld),
    .rd_ch   (slot_ch),
    .full    (req_full_o)
  );

  occ_best_pick #(
    .DEPTH  (REQ_DEPTH),
    .CH_W   (CH_W),
    .CNT_W  (CNT_W),
    .BANK_W (BANK_W),
    .IDX_W  (IDX_W)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start_i),
    .bank      (bank_i),
    .slot_idx  (slot_idx),
    .slot_vld  (slot_vld),
    .slot_ch   (slot_ch),
    .look_ch   (look_ch),
    .look_cnt  (look_cnt),
    .ready     (sel_ready_i),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .done      (done_o),
    .sel_valid (sel_valid_o),
    .sel_ch    (sel_ch_o),
    .sel_cnt   (sel_cnt_o)
  );
endmodule

// File: rtl/occ_sched_chk.sv
`timescale 1ns/1ps
module occ_sched_chk #(
  parameter int CH_W  = 9,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_push_i,
  input logic             req_full_o,
  input logic             done_o,
  input logic             sel_valid_o,
  input logic [CH_W-1:0]  sel_ch_o,
  input logic [CNT_W-1:0] sel_cnt_o,
  input logic             sel_ready_i,
  input logic             err_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid_o) |-> done_o); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && !sel_ready_i) |=>
      (sel_valid_o && $stable(sel_ch_o) && $stable(sel_cnt_o))); // R10

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && sel_ready_i) |=> !sel_valid_o); // R10

  AST_NO_EMPTY_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> (sel_cnt_o != '0)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R4

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_full_o && req_push_i && !(sel_valid_o && sel_ready_i)) |=> req_full_o); // R11
endmodule

bind occ_sched_top occ_sched_chk #(
  .CH_W  (CH_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_push_i  (req_push_i),
  .req_full_o  (req_full_o),
  .done_o      (done_o),
  .sel_valid_o (sel_valid_o),
  .sel_ch_o    (sel_ch_o),
  .sel_cnt_o   (sel_cnt_o),
  .sel_ready_i (sel_ready_i),
  .err_o       (err_o)
);

// File: tb/sim_occ_sched_top.sv
`timescale 1ns/1ps
module sim_occ_sched_top;
  localparam int NCH   = 16;
  localparam int CW    = 3;
  localparam int BW    = 2;
  localparam int DEPTH = 4;
  localparam int CHW   = 4;

  logic clk;
  logic rst_n;
  logic wr_done_i, rd_done_i, req_push_i, start_i, sel_ready_i;
  logic [CHW-1:0] wr_ch_i, rd_ch_i, req_ch_i;
  logic [BW-1:0]  bank_i;
  logic req_full_o, done_o, sel_valid_o, err_o;
  logic [CHW-1:0] sel_ch_o;
  logic [CW-1:0]  sel_cnt_o;

  int total;
  int bad;
  bit finished;

  occ_sched_top #(
    .NUM_CH(NCH), .CNT_W(CW), .BANK_W(BW), .REQ_DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_done_i(wr_done_i), .wr_ch_i(wr_ch_i),
    .rd_done_i(rd_done_i), .rd_ch_i(rd_ch_i),
    .req_push_i(req_push_i), .req_ch_i(req_ch_i), .req_full_o(req_full_o),
    .bank_i(bank_i), .start_i(start_i), .done_o(done_o),
    .sel_valid_o(sel_valid_o), .sel_ch_o(sel_ch_o), .sel_cnt_o(sel_cnt_o),
    .sel_ready_i(sel_ready_i), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      wr_done_i = 1'b1; wr_ch_i = CHW'(ch);
      step();
      wr_done_i = 1'b0;
    end
  endtask

  task automatic do_rd(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      rd_done_i = 1'b1; rd_ch_i = CHW'(ch);
      step();
      rd_done_i = 1'b0;
    end
  endtask

  task automatic push(input int ch);
    req_push_i = 1'b1; req_ch_i = CHW'(ch);
    step();
    req_push_i = 1'b0;
  endtask

  // Start a search, check latency and result, then accept after `hold` cycles.
  task automatic search(input int bank, input bit ev, input int ech,
                        input int ecnt, input int hold, input string req);
    int lat;
    bank_i = BW'(bank); start_i = 1'b1;
    step();
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      step();
      lat++;
    end
    chk(lat == DEPTH, "R6", "search latency", lat, DEPTH);
    chk(sel_valid_o == ev, req, "valid at done", int'(sel_valid_o), int'(ev));
    if (ev) begin
      chk(int'(sel_ch_o) == ech, req, "chosen channel", int'(sel_ch_o), ech);
      chk(int'(sel_cnt_o) == ecnt, req, "chosen count", int'(sel_cnt_o), ecnt);
    end
    step();
    chk(!done_o, "R6", "done width", int'(done_o), 0);
    if (ev) begin
      for (int i = 0; i < hold; i++) begin
        chk(sel_valid_o && int'(sel_ch_o) == ech, "R10", "held channel",
            int'(sel_ch_o), ech);
        step();
      end
      sel_ready_i = 1'b1;
      step();
      sel_ready_i = 1'b0;
    end
    chk(!sel_valid_o, "R10", "valid after accept", int'(sel_valid_o), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_done_i = 0; rd_done_i = 0; req_push_i = 0; start_i = 0; sel_ready_i = 0;
    wr_ch_i = '0; rd_ch_i = '0; req_ch_i = '0; bank_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!sel_valid_o, "R1", "valid after reset", int'(sel_valid_o), 0);
    chk(!done_o, "R1", "done after reset", int'(done_o), 0);
    chk(!err_o, "R1", "err after reset", int'(err_o), 0);
    chk(!req_full_o, "R1", "full after reset", int'(req_full_o), 0);
  endtask

  task automatic t_basic();
    do_wr(1, 2); do_wr(2, 3); do_wr(5, 5);
    push(1); push(2); push(5);
    search(0, 1, 2, 3, 3, "R7");
    search(0, 1, 1, 2, 0, "R7");
    search(1, 1, 5, 5, 1, "R7 R2");
  endtask

  task automatic t_dec();
    do_rd(5, 2);
    push(5);
    search(1, 1, 5, 3, 0, "R2");
  endtask

  task automatic t_cancel();
    wr_done_i = 1; wr_ch_i = 4'd5; rd_done_i = 1; rd_ch_i = 4'd5;
    step();
    rd_ch_i = 4'd1;
    step();
    wr_done_i = 0; rd_done_i = 0;
    chk(!err_o, "R3", "no error on cancel", int'(err_o), 0);
    push(5);
    search(1, 1, 5, 4, 0, "R3");
    push(1);
    search(0, 1, 1, 1, 0, "R2");
  endtask

  task automatic t_tie();
    do_wr(3, 1);
    push(3); push(1);
    search(0, 1, 1, 1, 0, "R8");
    search(0, 1, 3, 1, 0, "R8");
  endtask

  task automatic t_zero();
    push(0);
    do_wr(13, 4);
    push(13);
    search(0, 0, 0, 0, 0, "R9");
    search(3, 1, 13, 4, 0, "R9");
    do_wr(0, 1);
    search(0, 1, 0, 1, 0, "R9");
  endtask

  task automatic t_full();
    do_wr(8, 1); do_wr(9, 2); do_wr(10, 3); do_wr(11, 1);
    push(8); push(9); push(10); push(11);
    chk(req_full_o, "R11", "full after 4 pushes", int'(req_full_o), 1);
    do_wr(6, 1);
    push(6);
    search(1, 0, 0, 0, 0, "R11");
    search(2, 1, 10, 3, 0, "R11");
    chk(!req_full_o, "R11", "full after release", int'(req_full_o), 0);
    search(2, 1, 9, 2, 0, "R7");
    search(2, 1, 8, 1, 0, "R8");
    search(2, 1, 11, 1, 0, "R8");
    search(2, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_busy();
    int lat;
    push(9);
    bank_i = 2'd2; start_i = 1'b1;
    step();
    start_i = 1'b0;
    step();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    lat = 2;
    while (!done_o && lat < 40) begin
      step();
      lat++;
    end
    chk(lat == DEPTH, "R12", "latency with extra start", lat, DEPTH);
    chk(sel_valid_o && sel_ch_o == 4'd9, "R12", "result", int'(sel_ch_o), 9);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    sel_ready_i = 1'b1;
    step();
    sel_ready_i = 1'b0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      chk(!done_o && !sel_valid_o, "R12", "no stray search", int'(done_o), 0);
      step();
    end
  endtask

  task automatic t_under();
    do_rd(14, 1);
    chk(err_o, "R5", "err on underflow", int'(err_o), 1);
    step();
    chk(err_o, "R4", "err sticky", int'(err_o), 1);
    push(14);
    do_wr(14, 1);
    search(3, 1, 14, 1, 0, "R5");
  endtask

  task automatic t_sat();
    push(13);
    search(3, 0, 0, 0, 0, "R1");
    do_wr(12, 7);
    chk(!err_o, "R4", "no err at max", int'(err_o), 0);
    do_wr(12, 1);
    chk(err_o, "R4", "err on saturate", int'(err_o), 1);
    push(12);
    search(3, 1, 12, 7, 0, "R4");
    chk(err_o, "R4", "err still set", int'(err_o), 1);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    t_reset();
    t_basic();
    t_dec();
    t_cancel();
    t_tie();
    t_zero();
    t_full();
    t_busy();
    t_under();
    t_reset();
    t_sat();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule